// File: doc/BRIEF.md
# Pushbutton Power State Controller

This block is the top-level power state machine of a power-management device. It sequences the device through four states: a timed power-down hold, an off standby state, a powering-up state and an on state. The inputs that move it between states are an active-low pushbutton, a software power-on request level, a fault input, a hard-reset input and a power-good flag from the always-on supply. An external regulator sequencer receives a power-up request while the block is powering up and a power-down request while it is in power-down. The sequencer reports completion through a done input.

All timing is counted in periods of an external `tick` strobe. The power-down hold, the pushbutton acceptance time and the long-press hard-reset time are parameters. A simulation can therefore run with short counts, and silicon can use a slow real-time tick for the one-second and five-second intervals. The `SKIP_POR` parameter selects a variant that comes out of reset directly in standby and skips the power-down hold.

Top module: `pwrbtn_fsm`

## Requirements
- R1: With `SKIP_POR`=0, reset places the block in power-down: `state_code`=0, `rst_out_n`=0, `seq_down`=1, `seq_up`=0.
- R2: Power-down lasts exactly `POR_TICKS` clock edges with `tick` high, counted from entry, and then moves to standby. Edges with `tick` low do not advance the count.
- R3: `rst_out_n` is registered. It is high only when the block is outside power-down and `pg_aon` was high at the preceding edge.
- R4: With `SKIP_POR`=1, reset places the block in standby, and `rst_out_n` rises at the first edge at which `pg_aon` is high.
- R5: In standby, `btn_n` held low for `PRESS_TICKS` consecutive ticks moves the block to power-up. Releasing the button earlier restarts the count from zero.
- R6: In standby, `pwr_req` high moves the block to power-up at the next edge.
- R7: In power-up, `seq_done` high moves the block to the on state, unless a power-down cause (R8) is present at the same edge.
- R8: In power-up or on, any of `fault` high, `hard_rst` high, or `pwr_req` falling from 1 to 0 moves the block to power-down at the next edge.
- R9: In the on state, `btn_n` held low for `HOLD_TICKS` consecutive ticks acts as a hard reset and moves the block to power-down.
- R10: In standby, `fault` and `hard_rst` have no effect. The block stays in standby.
- R11: The state code is PDN=0, POFF=1, PUP=2, PON=3. `seq_up` is high exactly in PUP and `seq_down` is high exactly in PDN, and both are registered together with the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick | input | 1 | Timebase strobe, one clock wide |
| btn_n | input | 1 | Pushbutton, low when pressed |
| pwr_req | input | 1 | Software power-on request level |
| fault | input | 1 | Fault indication |
| hard_rst | input | 1 | Hard-reset request |
| pg_aon | input | 1 | Always-on supply power good |
| seq_done | input | 1 | Sequencer reports power-up complete |
| rst_out_n | output | 1 | Reset status, low while held |
| seq_up | output | 1 | Power-up sequence request |
| seq_down | output | 1 | Power-down sequence request |
| state_code | output | 2 | Current state (PDN=0, POFF=1, PUP=2, PON=3) |

## Verification
The embedded assertions check these properties on every cycle:
- the reset output is never released in power-down;
- a fault in an active state always lands in power-down;
- a request in standby always starts power-up;
- sequencer completion reaches the on state;
- standby is left only through a request or a press;
- power-down never advances without a tick.

Only the bench scenarios can show the exact tick counts of the hold, the press and the long-press windows, the restart of the press count on release, the falling-edge response to the request, and the skip variant's reset behaviour.

// File: rtl/pwrbtn_fsm.sv
module pwrbtn_fsm #(
  parameter int POR_TICKS   = 1000,
  parameter int HOLD_TICKS  = 5000,
  parameter int PRESS_TICKS = 50,
  parameter bit SKIP_POR    = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       btn_n,
  input  logic       pwr_req,
  input  logic       fault,
  input  logic       hard_rst,
  input  logic       pg_aon,
  input  logic       seq_done,
  output logic       rst_out_n,
  output logic       seq_up,
  output logic       seq_down,
  output logic [1:0] state_code
);
  localparam int MAXT  = (POR_TICKS > HOLD_TICKS) ?
                         ((POR_TICKS > PRESS_TICKS) ? POR_TICKS : PRESS_TICKS) :
                         ((HOLD_TICKS > PRESS_TICKS) ? HOLD_TICKS : PRESS_TICKS);
  localparam int CNT_W = $clog2(MAXT + 1);
  localparam logic [CNT_W-1:0] POR_END   = CNT_W'(POR_TICKS - 1);
  localparam logic [CNT_W-1:0] HOLD_END  = CNT_W'(HOLD_TICKS - 1);
  localparam logic [CNT_W-1:0] PRESS_END = CNT_W'(PRESS_TICKS - 1);

  typedef enum logic [1:0] {PDN = 2'd0, POFF = 2'd1, PUP = 2'd2, PON = 2'd3} st_t;
  localparam st_t INIT = SKIP_POR ? POFF : PDN;

  st_t state, nxt;
  logic [CNT_W-1:0] cnt;
  logic req_q;

  wire req_fall = req_q && !pwr_req;
  wire go_down  = fault || hard_rst || req_fall;
  wire pressed  = !btn_n && tick;

  always_comb begin
    nxt = state;
    case (state)
      PDN:  if (tick && cnt == POR_END) nxt = POFF;
      POFF: if (pwr_req || (pressed && cnt == PRESS_END)) nxt = PUP;
      PUP:  if (go_down) nxt = PDN;
            else if (seq_done) nxt = PON;
      PON:  if (go_down || (pressed && cnt == HOLD_END)) nxt = PDN;
      default: nxt = PDN;
    endcase
  end

  wire btn_state = (state == POFF) || (state == PON);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= INIT;
      cnt       <= '0;
      req_q     <= 1'b0;
      rst_out_n <= 1'b0;
      seq_up    <= 1'b0;
      seq_down  <= !SKIP_POR;
    end else begin
      state     <= nxt;
      req_q     <= pwr_req;
      rst_out_n <= pg_aon && (nxt != PDN);
      seq_up    <= (nxt == PUP);
      seq_down  <= (nxt == PDN);
      if (nxt != state || (btn_state && btn_n)) cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
    end
  end

  assign state_code = state;

  a_r3_rst_needs_on: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out_n |-> state != PDN);

  a_r8_fault_down: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PUP || state == PON) && fault) |=> state == PDN);

  a_r6_req_up: assert property (@(posedge clk) disable iff (!rst_n)
    (state == POFF && pwr_req) |=> state == PUP);

  a_r7_done_on: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PUP && seq_done && !fault && !hard_rst && !req_fall) |=> state == PON);

  a_r10_standby_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == POFF && !pwr_req && btn_n) |=> state == POFF);

  a_r2_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PDN && !tick) |=> state == PDN);

  a_r11_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_up && seq_down));
endmodule

// File: tb/pwrbtn_fsm_test.sv
module pwrbtn_fsm_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic btn_n = 1'b1, pwr_req = 1'b0, fault = 1'b0, hard_rst = 1'b0;
  logic pg_aon = 1'b1, seq_done = 1'b0;
  logic rst_out_n, seq_up, seq_down;
  logic [1:0] state_code;
  logic rst2_n = 1'b0, pg2 = 1'b0;
  logic rst2_out_n, up2, dn2;
  logic [1:0] st2;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  pwrbtn_fsm #(.POR_TICKS(4), .HOLD_TICKS(6), .PRESS_TICKS(3), .SKIP_POR(1'b0)) uut (
    .clk, .rst_n, .tick, .btn_n, .pwr_req, .fault, .hard_rst, .pg_aon, .seq_done,
    .rst_out_n, .seq_up, .seq_down, .state_code);

  pwrbtn_fsm #(.POR_TICKS(4), .HOLD_TICKS(6), .PRESS_TICKS(3), .SKIP_POR(1'b1)) uut2 (
    .clk, .rst_n(rst2_n), .tick(1'b1), .btn_n(1'b1), .pwr_req(1'b0), .fault(1'b0),
    .hard_rst(1'b0), .pg_aon(pg2), .seq_done(1'b0),
    .rst_out_n(rst2_out_n), .seq_up(up2), .seq_down(dn2), .state_code(st2));

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [1:0] es, input logic er);
    chk(req, {2'b0, state_code}, {2'b0, es});
    chk(req, {3'b0, rst_out_n}, {3'b0, er});
    chk("R11", {2'b0, seq_up, seq_down}, {2'b0, es == 2'd2, es == 2'd0});
  endtask

  // {btn_n,pwr_req,fault,hard_rst,pg_aon,seq_done}, edges, state, rst_out_n
  localparam int NV = 25;
  localparam logic [13:0] VEC [NV] = '{
    {6'b100010, 5'd3, 2'd0, 1'b0},  // R2 still holding
    {6'b100010, 5'd1, 2'd1, 1'b1},  // R2 R3 standby
    {6'b000010, 5'd2, 2'd1, 1'b1},  // R5 short press
    {6'b100010, 5'd1, 2'd1, 1'b1},  // R5 release
    {6'b000010, 5'd2, 2'd1, 1'b1},  // R5 restarted
    {6'b000010, 5'd1, 2'd2, 1'b1},  // R5 accepted
    {6'b100010, 5'd2, 2'd2, 1'b1},  // R7 waiting
    {6'b100011, 5'd1, 2'd3, 1'b1},  // R7 on
    {6'b101010, 5'd1, 2'd0, 1'b0},  // R8 fault
    {6'b100010, 5'd4, 2'd1, 1'b1},  // R2 re-timed
    {6'b110010, 5'd1, 2'd2, 1'b1},  // R6 request
    {6'b110011, 5'd1, 2'd3, 1'b1},  // R7
    {6'b100010, 5'd1, 2'd0, 1'b0},  // R8 request falls
    {6'b100010, 5'd4, 2'd1, 1'b1},  // R2
    {6'b110010, 5'd1, 2'd2, 1'b1},  // R6
    {6'b110011, 5'd1, 2'd3, 1'b1},  // R7
    {6'b010010, 5'd5, 2'd3, 1'b1},  // R9 not yet
    {6'b010010, 5'd1, 2'd0, 1'b0},  // R9 long press
    {6'b110010, 5'd4, 2'd1, 1'b1},  // R2
    {6'b100010, 5'd1, 2'd1, 1'b1},  // R6 no request stays
    {6'b101110, 5'd1, 2'd1, 1'b1},  // R10 fault+hard ignored
    {6'b100000, 5'd1, 2'd1, 1'b0},  // R3 power good lost
    {6'b100010, 5'd1, 2'd1, 1'b1},  // R3 restored
    {6'b110010, 5'd1, 2'd2, 1'b1},  // R6
    {6'b110110, 5'd1, 2'd0, 1'b0}   // R8 hard reset in power-up
  };

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk_all("R1", 2'd0, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      {btn_n, pwr_req, fault, hard_rst, pg_aon, seq_done} = VEC[i][13:8];
      repeat (int'(VEC[i][7:3])) @(posedge clk);
      @(negedge clk);
      chk_all($sformatf("vec%0d", i), VEC[i][2:1], VEC[i][0]);
    end

    // R2: edges without tick do not advance power-down
    {btn_n, pwr_req, fault, hard_rst, pg_aon, seq_done} = 6'b100010;
    rst_n = 1'b0;
    @(negedge clk);
    chk_all("R1", 2'd0, 1'b0);
    tick = 1'b0;
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk_all("R2", 2'd0, 1'b0);
    tick = 1'b1;
    repeat (3) @(negedge clk);
    chk_all("R2", 2'd0, 1'b0);
    @(negedge clk);
    chk_all("R2", 2'd1, 1'b1);

    // R4: variant starts in standby
    @(negedge clk);
    chk("R4", {2'b0, st2}, 4'd1);
    chk("R4", {1'b0, rst2_out_n, up2, dn2}, 4'b0000);
    rst2_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4", {2'b0, st2}, 4'd1);
    chk("R4", {3'b0, rst2_out_n}, 4'd0);
    pg2 = 1'b1;
    @(negedge clk);
    chk("R4", {1'b0, rst2_out_n, up2, dn2}, 4'b0100);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule